// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block tracks the receive buffers that host software leaves in a circular table in memory. Each table entry describes one buffer: a 32-bit start address and a 32-bit count of 16-bit words. On a command, the block reads the next entry through a word-read memory port and loads it as the current buffer. It then moves its read pointer to the next entry, returning to the ring start when the pointer reaches the ring end. It raises an exhaustion flag when the read pointer meets the host's write pointer.

The receive path presents the byte length of each arriving frame. The block pads that length for storage and checks whether it fits in the current buffer. It answers with a one-cycle decision pulse that carries accept or drop, the address at which the frame begins and the padded size. For an accepted frame it advances the buffer address and reduces the remaining word count. When the buffer runs short it either pulls the next entry from the ring or, if the ring is used up, stalls reception until the host supplies more buffers. The block does not write frame data or status records.

Top module: `rbrm_top`

## Requirements
- R1: After synchronous reset, the buffer address, word count, read pointer and status are zero, nothing is stalled or busy, and the end-of-buffer threshold is 0x02F8 words.
- R2: A fetch makes exactly four word reads at addresses {upper, read pointer} + k*S for k = 0..3, where S is 2 in 16-bit mode and 4 in 32-bit mode. Words 0 and 1 become the buffer address (low, high) and words 2 and 3 become the word count (low, high). A fetch starts on the fetch command, and the busy output is high in the cycle after the command.
- R3: A completed fetch advances the read pointer by 8 (16-bit mode) or 16 (32-bit mode) bytes. If the result equals the end pointer, the read pointer is reloaded from the start pointer.
- R4: Status bit 5 (exhausted) is set when the read pointer equals the write pointer after a fetch. Writing 1 to status bit 5 while it is set clears it and starts a fetch. Writing 1 to it while it is clear starts nothing.
- R5: Host writes to the start, end, read and write pointers are masked with 0xFFFC in 32-bit mode and 0xFFFE in 16-bit mode.
- R6: The padded size of a frame is its length plus 4, rounded up to a multiple of 4 (32-bit mode) or 2 (16-bit mode).
- R7: If the padded size exceeds twice the word count, the frame is dropped, status bit 4 (overflow) and the last-buffer flag are set, and the buffer address and count do not change. Writing 1 to status bit 4 clears it.
- R8: An accepted frame reports the previous buffer address as its pointer. The buffer address then grows by the padded size and the word count falls by half of it. A frame whose padded size equals twice the count is accepted.
- R9: The last-buffer flag is set when the count after storing is below the threshold. With the flag set, a fetch starts in the cycle after the decision unless the read pointer equals the write pointer.
- R10: With the flag set and the read pointer equal to the write pointer, the block stalls. While stalled, every frame is dropped with no change to any state. A completed fetch ends the stall.
- R11: Every frame request is answered by a decision pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_bus | input | 1 | 1 selects 32-bit memory mode, 0 selects 16-bit mode |
| reg_wr_en | input | 1 | Host pointer/threshold write strobe |
| reg_wr_sel | input | 3 | Target: 0 start, 1 end, 2 read, 3 write, 4 upper address, 5 threshold |
| reg_wr_data | input | 16 | Write data |
| cmd_fetch | input | 1 | Pulse: fetch the next ring entry |
| stat_clr | input | 16 | Write-one-to-clear mask for status bits 4 and 5 |
| mem_rd_en | output | 1 | Word read request |
| mem_rd_addr | output | 32 | Byte address of the read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data |
| frame_valid | input | 1 | Pulse: a frame awaits a decision |
| frame_len | input | 16 | Frame length in bytes |
| frame_done | output | 1 | Decision pulse |
| frame_accept | output | 1 | 1 when the frame is stored |
| frame_ptr | output | 32 | Start address for the frame |
| frame_bytes | output | 17 | Padded size of the frame |
| buf_addr | output | 32 | Current buffer address |
| word_cnt | output | 32 | Remaining words in the current buffer |
| rd_ptr | output | 16 | Ring read pointer |
| status | output | 16 | Bit 5 exhausted, bit 4 overflow |
| last_pkt | output | 1 | Last-buffer flag from the latest decision |
| stalled | output | 1 | Reception stalled |
| fetch_busy | output | 1 | Fetch in progress |

## Verification
The assertions assume that frames, fetch commands, status clears and pointer writes arrive only while the fetch is idle. They also assume that the bus mode stays fixed while a fetch or a decision is in flight, and that the memory returns one word for each request. The stimulus keeps to this by issuing every operation through a task that waits for the busy output to fall before it returns. The memory model answers each request after a fixed two-cycle delay. The scenarios walk through a wrap at the ring end, exhaustion and its clearing, an oversize drop that leads to a stall, and a frame that exactly fills its buffer.

// File: rtl/rbrm_pkg.sv
package rbrm_pkg;

  // host-visible write targets
  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_END   = 3'd1,
    SEL_READ  = 3'd2,
    SEL_WRITE = 3'd3,
    SEL_UPPER = 3'd4,
    SEL_EOB   = 3'd5
  } ring_sel_e;

  typedef enum logic [0:0] {
    F_IDLE = 1'b0,
    F_WAIT = 1'b1
  } fetch_state_e;

  // status bit positions (write-one-to-clear)
  localparam int STAT_OVF_BIT = 4;
  localparam int STAT_EXH_BIT = 5;

  // words per ring entry
  localparam int NWORDS = 4;

endpackage

// File: rtl/rbrm_ring.sv
module rbrm_ring
  import rbrm_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter logic [PTR_W-1:0] EOB_RESET = 16'h02F8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide_bus,
  input  logic             wr_en,
  input  ring_sel_e        wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             adv,
  input  logic             adv_wide,
  input  logic             clr_exh,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] upper,
  output logic [PTR_W-1:0] eob_thr,
  output logic             at_wp,
  output logic             exh_flag
);
  localparam logic [PTR_W-1:0] STEP_N = PTR_W'(2 * NWORDS);
  localparam logic [PTR_W-1:0] STEP_W = PTR_W'(4 * NWORDS);

  logic [PTR_W-1:0] sp_q, ep_q, rp_q, wp_q, up_q, eob_q;
  logic [PTR_W-1:0] wr_mask, wr_val, rp_sum, rp_nxt;

  always_comb begin
    wr_mask = wide_bus ? ~PTR_W'(3) : ~PTR_W'(1);
    wr_val  = wr_data & wr_mask;
    rp_sum  = rp_q + (adv_wide ? STEP_W : STEP_N);
    rp_nxt  = (rp_sum == ep_q) ? sp_q : rp_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q     <= '0;
      ep_q     <= '0;
      rp_q     <= '0;
      wp_q     <= '0;
      up_q     <= '0;
      eob_q    <= EOB_RESET;
      exh_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_START: sp_q  <= wr_val;
          SEL_END:   ep_q  <= wr_val;
          SEL_READ:  rp_q  <= wr_val;
          SEL_WRITE: wp_q  <= wr_val;
          SEL_UPPER: up_q  <= wr_data;
          SEL_EOB:   eob_q <= wr_data;
          default:   ;
        endcase
      end
      if (clr_exh) exh_flag <= 1'b0;
      if (adv) begin
        rp_q <= rp_nxt;
        if (rp_nxt == wp_q) exh_flag <= 1'b1;
      end
    end
  end

  assign rd_ptr  = rp_q;
  assign upper   = up_q;
  assign eob_thr = eob_q;
  assign at_wp   = (rp_q == wp_q);
endmodule

// File: rtl/rbrm_fetch.sv
module rbrm_fetch
  import rbrm_pkg::*;
#(
  parameter int PTR_W = 16,
  localparam int ADDR_W = 2 * PTR_W,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_bus,
  input  logic [ADDR_W-1:0] base,
  input  logic              mem_rd_valid,
  input  logic [PTR_W-1:0]  mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              busy,
  output logic              done,
  output logic              done_wide,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] res_cnt
);
  fetch_state_e      state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wide_q, en_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTR_W-1:0]  word_q [NWORDS];
  logic [ADDR_W-1:0] stride;

  assign stride = wide_q ? ADDR_W'(4) : ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= F_IDLE;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      for (int i = 0; i < NWORDS; i++) word_q[i] <= '0;
    end else begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        F_IDLE: begin
          if (start) begin
            wide_q  <= wide_bus;
            addr_q  <= base;
            idx_q   <= '0;
            en_q    <= 1'b1;
            state_q <= F_WAIT;
          end
        end
        F_WAIT: begin
          if (mem_rd_valid) begin
            word_q[idx_q] <= mem_rd_data;
            if (idx_q == IDX_W'(NWORDS - 1)) begin
              done_q  <= 1'b1;
              state_q <= F_IDLE;
            end else begin
              idx_q  <= idx_q + 1'b1;
              addr_q <= addr_q + stride;
              en_q   <= 1'b1;
            end
          end
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = en_q;
  assign mem_rd_addr = addr_q;
  assign busy        = (state_q != F_IDLE) | done_q;
  assign done        = done_q;
  assign done_wide   = wide_q;
  assign res_addr    = {word_q[1], word_q[0]};
  assign res_cnt     = {word_q[3], word_q[2]};
endmodule

// File: rtl/rbrm_space.sv
module rbrm_space #(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16,
  localparam int ADDR_W = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bus,
  input  logic              frame_valid,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] load_cnt,
  input  logic [PTR_W-1:0]  eob_thr,
  input  logic              at_wp,
  input  logic              ovf_clr,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] word_cnt,
  output logic              frame_done,
  output logic              frame_accept,
  output logic [ADDR_W-1:0] frame_ptr,
  output logic [LEN_W:0]    frame_bytes,
  output logic              last_pkt,
  output logic              stalled,
  output logic              ovf_flag,
  output logic              fetch_req
);
  logic [LEN_W:0]    rx_len, padded;
  logic              fits, lp_c;
  logic [ADDR_W-1:0] new_cnt;

  always_comb begin
    rx_len  = {1'b0, frame_len} + (LEN_W+1)'(4);
    padded  = ((rx_len - 1'b1) | (wide_bus ? (LEN_W+1)'(3) : (LEN_W+1)'(1))) + 1'b1;
    fits    = ((ADDR_W+1)'(padded) <= {word_cnt, 1'b0});
    new_cnt = word_cnt - ADDR_W'(padded >> 1);
    lp_c    = !stalled && (!fits || (new_cnt < ADDR_W'(eob_thr)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_addr     <= '0;
      word_cnt     <= '0;
      frame_done   <= 1'b0;
      frame_accept <= 1'b0;
      frame_ptr    <= '0;
      frame_bytes  <= '0;
      last_pkt     <= 1'b0;
      stalled      <= 1'b0;
      ovf_flag     <= 1'b0;
      fetch_req    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      fetch_req  <= 1'b0;
      if (ovf_clr) ovf_flag <= 1'b0;
      if (load) begin
        buf_addr <= load_addr;
        word_cnt <= load_cnt;
        stalled  <= 1'b0;
      end
      if (frame_valid) begin
        frame_done   <= 1'b1;
        frame_ptr    <= buf_addr;
        frame_bytes  <= padded;
        last_pkt     <= lp_c;
        frame_accept <= !stalled && fits;
        if (!stalled && !fits) ovf_flag <= 1'b1;
        if (!stalled && fits) begin
          buf_addr <= buf_addr + ADDR_W'(padded);
          word_cnt <= new_cnt;
        end
        if (lp_c) begin
          if (at_wp) stalled   <= 1'b1;
          else       fetch_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rbrm_top.sv
module rbrm_top
  import rbrm_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16,
  parameter logic [PTR_W-1:0] EOB_RESET = 16'h02F8,
  localparam int ADDR_W = 2 * PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bus,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_sel,
  input  logic [PTR_W-1:0]  reg_wr_data,
  input  logic              cmd_fetch,
  input  logic [15:0]       stat_clr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTR_W-1:0]  mem_rd_data,
  input  logic              frame_valid,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              frame_done,
  output logic              frame_accept,
  output logic [ADDR_W-1:0] frame_ptr,
  output logic [LEN_W:0]    frame_bytes,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] word_cnt,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [15:0]       status,
  output logic              last_pkt,
  output logic              stalled,
  output logic              fetch_busy
);
  logic [PTR_W-1:0]  upper, eob_thr;
  logic              at_wp, exh_flag, ovf_flag, fetch_req;
  logic              f_done, f_wide, f_start, clr_exh;
  logic [ADDR_W-1:0] f_addr, f_cnt;

  assign clr_exh = stat_clr[STAT_EXH_BIT] & exh_flag;
  assign f_start = !fetch_busy & (cmd_fetch | clr_exh | fetch_req);

  rbrm_ring #(.PTR_W(PTR_W), .EOB_RESET(EOB_RESET)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .wide_bus (wide_bus),
    .wr_en    (reg_wr_en),
    .wr_sel   (ring_sel_e'(reg_wr_sel)),
    .wr_data  (reg_wr_data),
    .adv      (f_done),
    .adv_wide (f_wide),
    .clr_exh  (clr_exh),
    .rd_ptr   (rd_ptr),
    .upper    (upper),
    .eob_thr  (eob_thr),
    .at_wp    (at_wp),
    .exh_flag (exh_flag)
  );

  rbrm_fetch #(.PTR_W(PTR_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .start        (f_start),
    .wide_bus     (wide_bus),
    .base         ({upper, rd_ptr}),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .busy         (fetch_busy),
    .done         (f_done),
    .done_wide    (f_wide),
    .res_addr     (f_addr),
    .res_cnt      (f_cnt)
  );

  rbrm_space #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_space (
    .clk          (clk),
    .rst          (rst),
    .wide_bus     (wide_bus),
    .frame_valid  (frame_valid),
    .frame_len    (frame_len),
    .load         (f_done),
    .load_addr    (f_addr),
    .load_cnt     (f_cnt),
    .eob_thr      (eob_thr),
    .at_wp        (at_wp),
    .ovf_clr      (stat_clr[STAT_OVF_BIT]),
    .buf_addr     (buf_addr),
    .word_cnt     (word_cnt),
    .frame_done   (frame_done),
    .frame_accept (frame_accept),
    .frame_ptr    (frame_ptr),
    .frame_bytes  (frame_bytes),
    .last_pkt     (last_pkt),
    .stalled      (stalled),
    .ovf_flag     (ovf_flag),
    .fetch_req    (fetch_req)
  );

  always_comb begin
    status               = '0;
    status[STAT_EXH_BIT] = exh_flag;
    status[STAT_OVF_BIT] = ovf_flag;
  end
endmodule

// File: rtl/rbrm_checker.sv
module rbrm_checker #(
  parameter int PTR_W = 16,
  parameter int LEN_W = 16,
  localparam int ADDR_W = 2 * PTR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_bus,
  input logic              reg_wr_en,
  input logic [2:0]        reg_wr_sel,
  input logic [PTR_W-1:0]  reg_wr_data,
  input logic              cmd_fetch,
  input logic [15:0]       stat_clr,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic [PTR_W-1:0]  mem_rd_data,
  input logic              frame_valid,
  input logic [LEN_W-1:0]  frame_len,
  input logic              frame_done,
  input logic              frame_accept,
  input logic [ADDR_W-1:0] frame_ptr,
  input logic [LEN_W:0]    frame_bytes,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [ADDR_W-1:0] word_cnt,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [15:0]       status,
  input logic              last_pkt,
  input logic              stalled,
  input logic              fetch_busy
);
  logic [2:0]        rd_cnt;
  logic [ADDR_W-1:0] last_addr;
  logic              wide_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt    <= '0;
      last_addr <= '0;
      wide_l    <= 1'b0;
    end else begin
      if (!fetch_busy) begin
        rd_cnt <= '0;
        wide_l <= wide_bus;
      end else if (mem_rd_en) begin
        rd_cnt <= rd_cnt + 1'b1;
      end
      if (mem_rd_en) last_addr <= mem_rd_addr;
    end
  end

  p_stride_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en && rd_cnt != 3'd0 |-> mem_rd_addr == last_addr + (wide_l ? ADDR_W'(4) : ADDR_W'(2)));
  p_four_reads_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> rd_cnt < 3'd4);
  p_exh_set_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[5]) |-> $past(fetch_busy));
  p_ptr_align_r5: assert property (@(posedge clk) disable iff (rst)
    rd_ptr[0] == 1'b0);
  p_pad_even_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> frame_bytes[0] == 1'b0);
  p_pad_wide_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done && wide_bus |-> frame_bytes[1:0] == 2'b00);
  p_ovf_drop_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> frame_done && !frame_accept && last_pkt);
  p_store_advance_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done && frame_accept |-> buf_addr == frame_ptr + ADDR_W'(frame_bytes));
  p_drop_stalled_r10: assert property (@(posedge clk) disable iff (rst)
    frame_valid && stalled |=> frame_done && !frame_accept);
  p_stall_end_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(stalled) |-> $past(fetch_busy));
  p_frame_done_r11: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> frame_done);
  p_quiet_input_r11: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> !fetch_busy);
endmodule

bind rbrm_top rbrm_checker #(.PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/rbrm_top_test.sv
`timescale 1ns/1ps
module rbrm_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_bus = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [15:0] reg_wr_data = '0;
  logic        cmd_fetch = 1'b0;
  logic [15:0] stat_clr = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_len = '0;
  logic        frame_done, frame_accept, last_pkt, stalled, fetch_busy;
  logic [31:0] frame_ptr, buf_addr, word_cnt;
  logic [16:0] frame_bytes;
  logic [15:0] rd_ptr, status;

  always #2 clk = ~clk;

  rbrm_top uut (.*);

  int n_chk = 0, n_err = 0;
  bit in_flight = 1'b1;
  bit done_flag = 1'b0;

  // reference model state
  logic [15:0] m_sp, m_ep, m_rp, m_wp, m_up, m_eob;
  logic [31:0] m_buf, m_wc;
  bit m_exh, m_ovf, m_stall, m_lp;
  logic [31:0] exp_q[$];
  logic [31:0] f_base;
  bit f_wide;
  logic [15:0] mem [0:2047];
  logic        p1_v = 1'b0;
  logic [31:0] p1_a = '0;

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory responder, two-cycle latency, address order checked (R2)
  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (exp_q.size() == 0) check_eq("R2", {32'd0, mem_rd_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
      else check_eq("R2", {32'd0, mem_rd_addr}, {32'd0, exp_q.pop_front()});
    end
    p1_v <= mem_rd_en;
    p1_a <= mem_rd_addr;
    mem_rd_valid <= p1_v;
    mem_rd_data  <= mem[p1_a[11:1]];
  end

  // per-cycle comparison while nothing is in flight
  always @(negedge clk) begin
    if (!rst && !in_flight && !done_flag) begin
      check_eq("R8 buf", {32'd0, buf_addr}, {32'd0, m_buf});
      check_eq("R8 cnt", {32'd0, word_cnt}, {32'd0, m_wc});
      check_eq("R3 rdptr", {48'd0, rd_ptr}, {48'd0, m_rp});
      check_eq("R4 status", {48'd0, status}, {58'd0, m_exh, m_ovf, 4'd0});
      check_eq("R10 stall", {63'd0, stalled}, {63'd0, m_stall});
      check_eq("R9 lastpkt", {63'd0, last_pkt}, {63'd0, m_lp});
      check_eq("R2 idle", {63'd0, fetch_busy}, 64'd0);
    end
  end

  function automatic logic [15:0] mask_ptr(input logic [15:0] v);
    return wide_bus ? (v & 16'hFFFC) : (v & 16'hFFFE);
  endfunction

  task automatic put_desc(input int a, input bit w, input logic [31:0] b, input logic [31:0] c);
    int s;
    s = w ? 4 : 2;
    mem[(a) >> 1]       = b[15:0];
    mem[(a + s) >> 1]   = b[31:16];
    mem[(a + 2*s) >> 1] = c[15:0];
    mem[(a + 3*s) >> 1] = c[31:16];
  endtask

  task automatic wr_reg(input int sel, input logic [15:0] val);
    @(posedge clk); #1;
    in_flight = 1; reg_wr_en = 1; reg_wr_sel = sel[2:0]; reg_wr_data = val;
    @(posedge clk); #1;
    reg_wr_en = 0;
    case (sel)
      0: m_sp = mask_ptr(val);
      1: m_ep = mask_ptr(val);
      2: m_rp = mask_ptr(val);
      3: m_wp = mask_ptr(val);
      4: m_up = val;
      default: m_eob = val;
    endcase
    in_flight = 0;
  endtask

  task automatic fetch_prepare();
    f_wide = wide_bus;
    f_base = {m_up, m_rp};
    for (int k = 0; k < 4; k++) exp_q.push_back(f_base + k * (f_wide ? 4 : 2));
  endtask

  task automatic fetch_finish();
    int s;
    logic [15:0] nxt;
    while (fetch_busy) begin @(posedge clk); #1; end
    s = f_wide ? 4 : 2;
    m_buf = {mem[((f_base + s) & 32'hFFF) >> 1], mem[(f_base & 32'hFFF) >> 1]};
    m_wc  = {mem[((f_base + 3*s) & 32'hFFF) >> 1], mem[((f_base + 2*s) & 32'hFFF) >> 1]};
    nxt = m_rp + (f_wide ? 16'd16 : 16'd8);
    if (nxt == m_ep) nxt = m_sp;
    m_rp = nxt;
    if (m_rp == m_wp) m_exh = 1;
    m_stall = 0;
  endtask

  task automatic cmd_fetch_op();
    @(posedge clk); #1;
    in_flight = 1; cmd_fetch = 1;
    fetch_prepare();
    @(posedge clk); #1;
    cmd_fetch = 0;
    check_eq("R2 busy", {63'd0, fetch_busy}, 64'd1);
    fetch_finish();
    in_flight = 0;
  endtask

  task automatic clear_stat(input logic [15:0] msk, input bit exp_fetch);
    bit go;
    @(posedge clk); #1;
    in_flight = 1; stat_clr = msk;
    go = msk[5] && m_exh;
    if (msk[4]) m_ovf = 0;
    if (msk[5]) m_exh = 0;
    if (go) fetch_prepare();
    @(posedge clk); #1;
    stat_clr = '0;
    check_eq("R4 clr-fetch", {63'd0, fetch_busy}, {63'd0, exp_fetch});
    if (go) fetch_finish();
    in_flight = 0;
  endtask

  task automatic send_frame(input int len);
    int pad;
    bit go;
    pad = ((len + 3) | (wide_bus ? 3 : 1)) + 1;
    @(posedge clk); #1;
    in_flight = 1; frame_valid = 1; frame_len = len[15:0];
    @(posedge clk); #1;
    frame_valid = 0;
    check_eq("R11 done", {63'd0, frame_done}, 64'd1);
    go = 0;
    if (m_stall) begin
      check_eq("R10 drop", {63'd0, frame_accept}, 64'd0);
      m_lp = 0;
    end else begin
      check_eq("R6 pad", {47'd0, frame_bytes}, 64'(pad));
      if (longint'(pad) > 2 * longint'(m_wc)) begin
        check_eq("R7 drop", {63'd0, frame_accept}, 64'd0);
        m_ovf = 1; m_lp = 1;
      end else begin
        check_eq("R8 accept", {63'd0, frame_accept}, 64'd1);
        check_eq("R8 ptr", {32'd0, frame_ptr}, {32'd0, m_buf});
        m_buf = m_buf + pad;
        m_wc  = m_wc - pad / 2;
        m_lp  = (m_wc < {16'd0, m_eob});
      end
      if (m_lp) begin
        if (m_rp == m_wp) m_stall = 1;
        else go = 1;
      end
    end
    if (go) begin
      fetch_prepare();
      @(posedge clk); #1;
      check_eq("R9 autofetch", {63'd0, fetch_busy}, 64'd1);
      fetch_finish();
    end
    in_flight = 0;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    put_desc(32'h100, 0, 32'h0000_2000, 32'h0000_0300);
    put_desc(32'h108, 0, 32'h0000_3000, 32'h0000_0040);
    put_desc(32'h110, 0, 32'h0000_4000, 32'h0000_0010);
    put_desc(32'h118, 0, 32'h0000_5000, 32'h0000_1000);
    put_desc(32'h200, 1, 32'h0000_6000, 32'h0000_0100);
    put_desc(32'h210, 1, 32'h0000_7000, 32'h0000_0080);
    m_sp = 0; m_ep = 0; m_rp = 0; m_wp = 0; m_up = 0; m_eob = 16'h02F8;
    m_buf = 0; m_wc = 0; m_exh = 0; m_ovf = 0; m_stall = 0; m_lp = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 buf", {32'd0, buf_addr}, 64'd0);
    check_eq("R1 cnt", {32'd0, word_cnt}, 64'd0);
    check_eq("R1 status", {48'd0, status}, 64'd0);
    check_eq("R1 stall", {62'd0, stalled, fetch_busy}, 64'd0);
    check_eq("R1 done", {63'd0, frame_done}, 64'd0);
    in_flight = 0;

    // 16-bit ring: start 0x100, end 0x120, write 0x118
    wr_reg(0, 16'h0101);
    wr_reg(1, 16'h0120);
    wr_reg(3, 16'h0119);
    wr_reg(2, 16'h0107);
    check_eq("R5 mask16", {48'd0, rd_ptr}, 64'h0106);
    wr_reg(2, 16'h0100);
    cmd_fetch_op();                 // R2 R3
    send_frame(60);                 // R1 threshold 0x2F8 -> R9 fetch
    send_frame(61);                 // R6 odd length, fetch reaches write ptr -> R4
    check_eq("R4 exh", {63'd0, status[5]}, 64'd1);
    wr_reg(5, 16'h0002);
    send_frame(20);                 // R8 plain store
    send_frame(10);                 // R7 oversize -> R10 stall
    check_eq("R7 ovf", {63'd0, status[4]}, 64'd1);
    check_eq("R10 stalled", {63'd0, stalled}, 64'd1);
    send_frame(4);                  // R10 dropped while stalled
    clear_stat(16'h0010, 1'b0);     // R7 clear overflow only
    clear_stat(16'h0020, 1'b1);     // R4 clear starts fetch, R3 wrap
    check_eq("R3 wrap", {48'd0, rd_ptr}, 64'h0100);
    clear_stat(16'h0020, 1'b0);     // R4 clear of a clear bit

    // 32-bit ring at upper 0x0001
    wide_bus = 1'b1;
    wr_reg(2, 16'h0207);
    check_eq("R5 mask32", {48'd0, rd_ptr}, 64'h0204);
    wr_reg(0, 16'h0200);
    wr_reg(1, 16'h0220);
    wr_reg(3, 16'h021F);
    wr_reg(4, 16'h0001);
    wr_reg(2, 16'h0200);
    cmd_fetch_op();                 // R2 stride 4
    send_frame(61);                 // R6 pad to 68
    cmd_fetch_op();                 // R3 wrap in 32-bit mode
    check_eq("R3 wrap32", {48'd0, rd_ptr}, 64'h0200);
    cmd_fetch_op();
    send_frame(508);                // R8 exact fit, R9 fetch
    check_eq("R8 exact", {32'd0, buf_addr}, 64'h7000);
    repeat (4) @(posedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule